// File: doc/BRIEF.md
# Indexed-Access Real-Time Clock Registers

This block is a calendar clock that software reaches through two byte-wide ports. A write to the index port picks one of 128 locations, and every later access to the data port reads or writes that location. Only the low seven bits of an index write select the location. The top bit of an index write is kept and driven out as a separate gate signal for the non-maskable interrupt.

The block keeps seconds, minutes and hours, each with an alarm register. It also keeps the day of the week, the day of the month, the month and a two-digit year. It advances once for each pulse on a one-second tick input, and it can be halted. Two status registers set the number format (BCD or binary) and the hour format (12 or 24 hours). They also set the interrupt enables and the periodic rate.

A third status register, read-only, reports the periodic, alarm and update-ended events. Reading it clears them. A periodic event is made by dividing a fast tick input by a power of two. All locations above the status registers are plain byte storage.

Top module: `idx_rtc`

## Requirements
- R1: Writing the index port (bus_sel=0) stores bits 6:0 as the current index and drives bit 7 onto nmi_gate, where 1 blocks the NMI and 0 passes it. A data-port access (bus_sel=1) reaches the location named by the last index write. A read of the index port returns {nmi_gate, index}.
- R2: Locations 0x0D to 0x7F are general storage. Each returns the last byte written to it.
- R3: After reset, locations 0x00 to 0x05 and 0x09 read 0x00, and 0x06, 0x07 and 0x08 read 0x01. Status A (0x0A) reads 0x00, status B (0x0B) reads 0x02 and status C (0x0C) reads 0x80. Both nmi_gate and irq are 0.
- R4: Time locations are seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, date 0x07, month 0x08 and year 0x09. Alarm seconds, minutes and hours are at 0x01, 0x03 and 0x05. A sec_tick pulse with halt clear sets status A bit 7 for UIP_CYC cycles. Seconds then advance by one, and each field that rolls over carries into the next: seconds, then minutes, hours, date, month and year.
- R5: Status B bit 2 = 0 holds every time field in BCD, two digits per nibble. Bit 2 = 1 holds it in plain binary.
- R6: Status B bit 1 = 1 keeps hours 0 to 23. Bit 1 = 0 keeps hours 1 to 12, with bit 7 of the hours byte set for PM. After 11 PM comes 12 AM, and after 11 AM comes 12 PM.
- R7: Month lengths are 31, 28 and 30 days by month. February has 29 days when the year is a multiple of 4. The weekday counts 1 to 7 and wraps to 1, and the year counts 00 to 99 and wraps to 00.
- R8: While status B bit 7 = 1, sec_tick is ignored. The time does not change and status A bit 7 stays 0.
- R9: Status C bit 7 always reads 1. Bit 4 is set after each update. Bit 5 is set when seconds, minutes and hours equal their alarm registers after an update. A read of status C returns the flags and clears them.
- R10: A write to status A restarts the periodic divider. With rate r = A[3:0] between 1 and 15, status C bit 6 is set on the 2^(r-1)-th fast_tick pulse. With r = 0 the bit is never set.
- R11: irq is 1 exactly when a status C flag is set and its enable is set. The enables are status B bits 6, 5 and 4, for the periodic, alarm and update flags in that order.
- R12: A data write to a time register in the same cycle as an update keeps the written value, while the other fields still update. A flag raised in the same cycle as a status C read survives that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_rd | input | 1 | Read strobe for the selected port |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle after bus_rd |
| sec_tick | input | 1 | One-second update pulse |
| fast_tick | input | 1 | Base pulse for the periodic divider |
| irq | output | 1 | Registered interrupt request |
| nmi_gate | output | 1 | Bit 7 of the last index write |

## Verification
Two kinds of work can collide in the cycle where an update completes. Software can write a time field in that cycle, and software can read status C in that cycle. The bench counts cycles from the tick edge so that a data write to the seconds register, or a read of status C, is sampled on exactly the commit edge. It then requires that the written seconds value is kept while the minutes still carry. It also requires that the read returns the old flags and that the update-ended flag is still set on the next read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned N_TIME = 10;

  localparam logic [6:0] IX_SEC  = 7'h00;
  localparam logic [6:0] IX_HR   = 7'h04;
  localparam logic [6:0] IX_STA  = 7'h0A;
  localparam logic [6:0] IX_STB  = 7'h0B;
  localparam logic [6:0] IX_STC  = 7'h0C;
  localparam logic [6:0] IX_MEM0 = 7'h0D;

  // field value as a plain number
  function automatic logic [7:0] dec_val(input logic [7:0] v, input logic bin);
    return bin ? v : 8'(v[7:4] * 10 + v[3:0]);
  endfunction

  // plain number to the stored format
  function automatic logic [7:0] enc_val(input logic [7:0] n, input logic bin);
    return bin ? n : {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'd2:                     return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

  function automatic logic [7:0] hr_to24(input logic [7:0] v, input logic bin, input logic h24);
    logic [7:0] h12;
    if (h24) return dec_val(v, bin);
    h12 = dec_val({1'b0, v[6:0]}, bin);
    return ((h12 == 8'd12) ? 8'd0 : h12) + (v[7] ? 8'd12 : 8'd0);
  endfunction

  function automatic logic [7:0] hr_from24(input logic [7:0] n, input logic bin, input logic h24);
    logic [7:0] h;
    logic [7:0] e;
    if (h24) return enc_val(n, bin);
    h = n % 12;
    if (h == 8'd0) h = 8'd12;
    e = enc_val(h, bin);
    return {(n >= 8'd12), e[6:0]};
  endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int unsigned UIP_CYC = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      halt,
  input  logic                      bin_fmt,
  input  logic                      h24,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [7:0]                wr_data,
  output logic [N_TIME-1:0][7:0]    tq,
  output logic                      uip,
  output logic                      commit,
  output logic                      alarm_hit
);
  localparam int unsigned CW = $clog2(UIP_CYC + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [N_TIME-1:0][7:0] nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (tick && !halt) begin
      busy <= 1'b1;
      cnt  <= CW'(UIP_CYC - 1);
    end
  end

  assign uip    = busy;
  assign commit = busy && (cnt == '0);

  always_comb begin
    logic [7:0] s, m, h, dw, dm, mo, yr, dim;
    s  = dec_val(tq[0], bin_fmt);
    m  = dec_val(tq[2], bin_fmt);
    h  = hr_to24(tq[4], bin_fmt, h24);
    dw = dec_val(tq[6], bin_fmt);
    dm = dec_val(tq[7], bin_fmt);
    mo = dec_val(tq[8], bin_fmt);
    yr = dec_val(tq[9], bin_fmt);
    dim = month_days(mo, yr);
    s = s + 8'd1;
    if (s >= 8'd60) begin
      s = 8'd0;
      m = m + 8'd1;
      if (m >= 8'd60) begin
        m = 8'd0;
        h = h + 8'd1;
        if (h >= 8'd24) begin
          h  = 8'd0;
          dw = (dw >= 8'd7 || dw == 8'd0) ? 8'd1 : dw + 8'd1;
          dm = dm + 8'd1;
          if (dm > dim) begin
            dm = 8'd1;
            mo = mo + 8'd1;
            if (mo > 8'd12) begin
              mo = 8'd1;
              yr = (yr >= 8'd99) ? 8'd0 : yr + 8'd1;
            end
          end
        end
      end
    end
    nx    = tq;
    nx[0] = enc_val(s, bin_fmt);
    nx[2] = enc_val(m, bin_fmt);
    nx[4] = hr_from24(h, bin_fmt, h24);
    nx[6] = enc_val(dw, bin_fmt);
    nx[7] = enc_val(dm, bin_fmt);
    nx[8] = enc_val(mo, bin_fmt);
    nx[9] = enc_val(yr, bin_fmt);
  end

  assign alarm_hit = commit && (nx[0] == tq[1]) && (nx[2] == tq[3]) && (nx[4] == tq[5]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(N_TIME); i++)
        tq[i] <= (i == 6 || i == 7 || i == 8) ? 8'h01 : 8'h00;
    end else begin
      for (int i = 0; i < int'(N_TIME); i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) tq[i] <= wr_data;
        else if (commit)                  tq[i] <= nx[i];
      end
    end
  end
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       fast_tick,
  input  logic [3:0] rate,
  output logic       pulse
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] mask;

  assign mask  = (rate == 4'd0) ? '0 : DIV_W'((32'd1 << (rate - 4'd1)) - 32'd1);
  assign pulse = fast_tick && (rate != 4'd0) && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (fast_tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_store.sv
module rtc_store #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    dout <= mem[addr];
  end
endmodule

// File: rtl/idx_rtc.sv
module idx_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned UIP_CYC = 8,
  parameter int unsigned DIV_W   = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sec_tick,
  input  logic       fast_tick,
  output logic       irq,
  output logic       nmi_gate
);
  logic [IDX_W-1:0]       idx_q;
  logic                   nmi_q;
  logic [6:0]             sta_q;
  logic [7:0]             stb_q;
  logic [2:0]             flg_q;
  logic [2:0]             flg_nxt;
  logic                   irq_q;
  logic [7:0]             rd_q;
  logic                   ram_sel_q;
  logic [7:0]             ram_dout;
  logic [N_TIME-1:0][7:0] tq;
  logic                   uip, commit, alarm_hit, pf_pulse;

  logic data_wr, data_rd, rd_c, is_time, is_mem;
  assign data_wr = bus_wr && bus_sel;
  assign data_rd = bus_rd && bus_sel;
  assign is_time = idx_q < IDX_W'(N_TIME);
  assign is_mem  = idx_q >= IX_MEM0;
  assign rd_c    = data_rd && idx_q == IX_STC;

  rtc_time_core #(.UIP_CYC(UIP_CYC)) u_core (
    .clk(clk), .rst(rst), .tick(sec_tick), .halt(stb_q[7]),
    .bin_fmt(stb_q[2]), .h24(stb_q[1]),
    .wr_en(data_wr && is_time), .wr_idx(idx_q), .wr_data(bus_wdata),
    .tq(tq), .uip(uip), .commit(commit), .alarm_hit(alarm_hit)
  );

  rtc_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(data_wr && idx_q == IX_STA),
    .fast_tick(fast_tick), .rate(sta_q[3:0]), .pulse(pf_pulse)
  );

  rtc_store #(.AW(IDX_W), .DW(8)) u_mem (
    .clk(clk), .we(data_wr && is_mem), .addr(idx_q),
    .wdata(bus_wdata), .dout(ram_dout)
  );

  // new events win over the clear-on-read
  assign flg_nxt = (rd_c ? 3'b000 : flg_q) | {pf_pulse, alarm_hit, commit};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      nmi_q <= 1'b0;
      sta_q <= '0;
      stb_q <= 8'h02;
      flg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (bus_wr && !bus_sel) begin
        idx_q <= bus_wdata[6:0];
        nmi_q <= bus_wdata[7];
      end
      if (data_wr && idx_q == IX_STA) sta_q <= bus_wdata[6:0];
      if (data_wr && idx_q == IX_STB) stb_q <= bus_wdata;
      flg_q <= flg_nxt;
      irq_q <= |(flg_nxt & stb_q[6:4]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      ram_sel_q <= 1'b0;
    end else if (bus_rd) begin
      ram_sel_q <= bus_sel && is_mem;
      if (!bus_sel)               rd_q <= {nmi_q, idx_q};
      else if (is_time)           rd_q <= tq[idx_q[3:0]];
      else if (idx_q == IX_STA)   rd_q <= {uip, sta_q};
      else if (idx_q == IX_STB)   rd_q <= stb_q;
      else if (idx_q == IX_STC)   rd_q <= {1'b1, flg_q, 4'b0000};
      else                        rd_q <= '0;
    end
  end

  assign bus_rdata = ram_sel_q ? ram_dout : rd_q;
  assign irq       = irq_q;
  assign nmi_gate  = nmi_q;
endmodule

// File: rtl/idx_rtc_chk.sv
module idx_rtc_chk (
  input logic       clk,
  input logic       rst,
  input logic       sec_tick,
  input logic       halt,
  input logic       uip,
  input logic       commit,
  input logic [2:0] flg,
  input logic       irq,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic [7:0] bus_wdata,
  input logic       nmi_gate,
  input logic       rd_c,
  input logic [7:0] bus_rdata
);
  // R1
  nmi_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_sel) |=> (nmi_gate == $past(bus_wdata[7])));

  // R4
  uip_start_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !halt && !uip) |=> uip);

  // R4
  commit_in_uip_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> uip);

  // R8
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !uip) |=> !uip);

  // R9
  power_bit_chk: assert property (@(posedge clk) disable iff (rst)
    rd_c |=> bus_rdata[7]);

  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flg == 3'b000) |-> !irq);
endmodule

bind idx_rtc idx_rtc_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .halt(stb_q[7]), .uip(uip),
  .commit(commit), .flg(flg_q), .irq(irq), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .nmi_gate(nmi_gate), .rd_c(rd_c), .bus_rdata(bus_rdata)
);

// File: tb/idx_rtc_bench.sv
module idx_rtc_bench;
  localparam int UIP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sec_tick = 1'b0, fast_tick = 1'b0;
  logic irq, nmi_gate;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  idx_rtc #(.UIP_CYC(UIP), .DIV_W(15)) u_idx_rtc (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .fast_tick(fast_tick), .irq(irq), .nmi_gate(nmi_gate)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int n, input bit bin);
    return bin ? 8'(n) : 8'((n / 10) * 16 + n % 10);
  endfunction

  function automatic logic [7:0] enc12(input int n24, input bit bin);
    int h;
    logic [7:0] e;
    h = n24 % 12;
    if (h == 0) h = 12;
    e = enc(h, bin);
    return {n24 >= 12, e[6:0]};
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic port_wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic port_rd(input bit sel, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wr_reg(input logic [6:0] i, input logic [7:0] d);
    port_wr(1'b0, {1'b0, i});
    port_wr(1'b1, d);
  endtask

  task automatic rd_reg(input logic [6:0] i, output logic [7:0] v);
    port_wr(1'b0, {1'b0, i});
    port_rd(1'b1, v);
  endtask

  task automatic pulse_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic tick_wait();
    pulse_tick();
    repeat (UIP + 2) @(negedge clk);
  endtask

  task automatic pulse_fast();
    @(negedge clk); fast_tick = 1'b1;
    @(negedge clk); fast_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    check("R3 nmi_gate", {7'd0, nmi_gate}, 8'h00);
    check("R3 irq", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 10; i++) begin
      rd_reg(7'(i), v);
      check("R3 time field", v, (i >= 6 && i <= 8) ? 8'h01 : 8'h00);
    end
    rd_reg(7'h0A, v); check("R3 status A", v, 8'h00);
    rd_reg(7'h0B, v); check("R3 status B", v, 8'h02);
    rd_reg(7'h0C, v); check("R3 status C", v, 8'h80);

    // R2 storage sweep
    for (int i = 13; i < 128; i++) wr_reg(7'(i), 8'(i) ^ 8'hA5);
    for (int i = 13; i < 128; i++) begin
      rd_reg(7'(i), v);
      check("R2 storage", v, 8'(i) ^ 8'hA5);
    end

    // R1 index port, nmi gate
    port_wr(1'b0, 8'h80 | 8'd20);
    check("R1 nmi_gate set", {7'd0, nmi_gate}, 8'h01);
    port_wr(1'b1, 8'h3C);
    port_rd(1'b0, v); check("R1 index readback", v, 8'h94);
    port_rd(1'b1, v); check("R1 data via gated index", v, 8'h3C);
    port_wr(1'b0, 8'd20);
    check("R1 nmi_gate clear", {7'd0, nmi_gate}, 8'h00);

    // R4 R5 seconds sweeps, BCD then binary
    for (int f = 0; f < 2; f++) begin
      wr_reg(7'h0B, f ? 8'h06 : 8'h02);
      for (int s = 0; s < 60; s++) begin
        wr_reg(7'h02, enc(0, f != 0));
        wr_reg(7'h00, enc(s, f != 0));
        tick_wait();
        rd_reg(7'h00, v); check("R5 seconds advance", v, enc((s + 1) % 60, f != 0));
        if (s == 59) begin
          rd_reg(7'h02, v); check("R4 minute carry", v, enc(1, f != 0));
        end
      end
    end
    // R4 update-in-progress window
    wr_reg(7'h0B, 8'h02);
    pulse_tick();
    rd_reg(7'h0A, v); check("R4 uip during update", v & 8'h80, 8'h80);
    repeat (UIP) @(negedge clk);
    rd_reg(7'h0A, v); check("R4 uip after update", v & 8'h80, 8'h00);

    // R6 hour sweeps: 12h BCD and 24h binary
    for (int f = 0; f < 2; f++) begin
      wr_reg(7'h0B, f ? 8'h06 : 8'h00);
      for (int h = 0; h < 24; h++) begin
        wr_reg(7'h04, f ? enc(h, 1'b1) : enc12(h, 1'b0));
        wr_reg(7'h02, enc(59, f != 0));
        wr_reg(7'h00, enc(59, f != 0));
        tick_wait();
        rd_reg(7'h04, v);
        check("R6 hour advance", v, f ? enc((h + 1) % 24, 1'b1) : enc12((h + 1) % 24, 1'b0));
      end
    end

    // R7 month ends across a leap and a common year, plus year wrap
    wr_reg(7'h0B, 8'h02);
    for (int yi = 0; yi < 3; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int yr;
        yr = (yi == 0) ? 23 : (yi == 1) ? 24 : 99;
        if (yi == 2 && mo != 12) continue;
        wr_reg(7'h09, enc(yr, 1'b0));
        wr_reg(7'h08, enc(mo, 1'b0));
        wr_reg(7'h07, enc(mdays(mo, yr), 1'b0));
        wr_reg(7'h06, 8'h07);
        wr_reg(7'h04, 8'h23);
        wr_reg(7'h02, 8'h59);
        wr_reg(7'h00, 8'h59);
        tick_wait();
        rd_reg(7'h07, v); check("R7 date wraps", v, 8'h01);
        rd_reg(7'h08, v); check("R7 month next", v, enc(mo % 12 + 1, 1'b0));
        rd_reg(7'h09, v); check("R7 year", v, enc((mo == 12) ? (yr + 1) % 100 : yr, 1'b0));
        rd_reg(7'h06, v); check("R7 weekday wraps", v, 8'h01);
      end
    end
    // R7 leap day is not a month end
    wr_reg(7'h09, 8'h24); wr_reg(7'h08, 8'h02); wr_reg(7'h07, 8'h28);
    wr_reg(7'h04, 8'h23); wr_reg(7'h02, 8'h59); wr_reg(7'h00, 8'h59);
    tick_wait();
    rd_reg(7'h07, v); check("R7 Feb 29 in leap year", v, 8'h29);

    // R8 halt
    wr_reg(7'h0B, 8'h82);
    wr_reg(7'h00, 8'h10);
    pulse_tick();
    rd_reg(7'h0A, v); check("R8 no uip while halted", v & 8'h80, 8'h00);
    repeat (UIP + 2) @(negedge clk);
    rd_reg(7'h00, v); check("R8 time frozen", v, 8'h10);

    // R9 flags and clear-on-read
    wr_reg(7'h0B, 8'h02);
    rd_reg(7'h0C, v);
    wr_reg(7'h04, 8'h00); wr_reg(7'h02, 8'h00); wr_reg(7'h00, 8'h05);
    wr_reg(7'h05, 8'h00); wr_reg(7'h03, 8'h00); wr_reg(7'h01, 8'h06);
    tick_wait();
    check("R11 no irq without enable", {7'd0, irq}, 8'h00);
    rd_reg(7'h0C, v); check("R9 update and alarm flags", v, 8'hB0);
    rd_reg(7'h0C, v); check("R9 flags cleared by read", v, 8'h80);
    tick_wait();
    rd_reg(7'h0C, v); check("R9 update flag only", v, 8'h90);

    // R11 alarm interrupt
    wr_reg(7'h0B, 8'h22);
    wr_reg(7'h00, 8'h05);
    tick_wait();
    check("R11 irq on alarm", {7'd0, irq}, 8'h01);
    rd_reg(7'h0C, v);
    check("R11 irq cleared by read", {7'd0, irq}, 8'h00);
    tick_wait();
    check("R11 update flag not enabled", {7'd0, irq}, 8'h00);

    // R10 periodic divider sweep
    wr_reg(7'h0B, 8'h02);
    for (int r = 1; r <= 4; r++) begin
      wr_reg(7'h0A, 8'(r));
      rd_reg(7'h0C, v);
      for (int k = 0; k < (1 << (r - 1)) - 1; k++) pulse_fast();
      rd_reg(7'h0C, v); check("R10 periodic not yet", v & 8'h40, 8'h00);
      pulse_fast();
      rd_reg(7'h0C, v); check("R10 periodic set", v & 8'h40, 8'h40);
    end
    wr_reg(7'h0A, 8'h00);
    rd_reg(7'h0C, v);
    for (int k = 0; k < 20; k++) pulse_fast();
    rd_reg(7'h0C, v); check("R10 rate zero silent", v & 8'h40, 8'h00);
    wr_reg(7'h0B, 8'h42);
    wr_reg(7'h0A, 8'h01);
    pulse_fast();
    @(negedge clk);
    check("R11 irq on periodic", {7'd0, irq}, 8'h01);
    rd_reg(7'h0C, v);
    wr_reg(7'h0B, 8'h02);

    // R12 write lands on the commit edge
    wr_reg(7'h02, 8'h10);
    wr_reg(7'h00, 8'h59);
    pulse_tick();
    repeat (UIP - 1) @(negedge clk);
    bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h30;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rd_reg(7'h00, v); check("R12 written seconds kept", v, 8'h30);
    rd_reg(7'h02, v); check("R12 minutes still carry", v, 8'h11);

    // R12 status C read lands on the commit edge
    rd_reg(7'h0C, v);
    port_wr(1'b0, 8'h0C);
    pulse_tick();
    repeat (UIP - 1) @(negedge clk);
    bus_rd = 1'b1; bus_sel = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R12 read sees old flags", bus_rdata, 8'h80);
    repeat (2) @(negedge clk);
    rd_reg(7'h0C, v); check("R12 new flag survives read", v, 8'h90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule